// File: doc/BRIEF.md
# ADC Serial Conversion Sequencer

This block is the host-side controller for one conversion on a multichannel 16-bit serial ADC. A start request loads an 8-bit command and a mode bit. The block then drops the chip select and generates SCLK from the system clock. It shifts the command out MSB first and collects the 16-bit result from the converter's data output. When it is done it raises chip select again, and it keeps chip select high for a minimum number of clocks before another cycle may begin.

The block has two conversion modes. In the continuous mode, SCLK runs for 32 cycles without a pause: the command is sent on the first eight, and the result comes back on the last sixteen. In the paused mode, SCLK stops low after the command byte. The block then waits for the converter's end-of-conversion line to fall, and only after that does it restart SCLK to read the sixteen result bits. A watchdog ends a paused wait that lasts too long. An abort input ends any cycle at once and discards the partial result.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, cs_n is 1, and sclk, din, busy, result_valid, timeout and result are all 0.
- R2: The command byte is sent MSB first on the first 8 SCLK rising edges after cs_n falls. din changes only while sclk is 0.
- R3: Each SCLK half-period lasts max(half_div,1) system clocks, so one SCLK period is twice that. half_div is latched at start. sclk is 0 whenever cs_n is 1, and sclk is 0 when a cycle begins.
- R4: With int_mode=0, SCLK gives exactly 32 rising edges while cs_n is low. dout is sampled on rising edges 17 to 32, and the first sampled bit is result bit 15.
- R5: With int_mode=1, SCLK stops low after the 8th rising edge until an EOC falling edge is seen. It then gives 16 more rising edges (24 in total), and dout is sampled on each of them, MSB first.
- R6: EOC passes through a two-flop synchronizer and a fall detector. SCLK rises again 2+max(half_div,1) clocks after the first clock edge at which the low level is sampled. An EOC fall outside the paused wait has no effect.
- R7: result_valid is a one-clock pulse in the first clock after cs_n has returned high. result is updated at that time and then held.
- R8: After any end of cycle, cs_n stays high for at least CSW_CLKS clocks before it falls again.
- R9: A start request while busy is high, including the guard interval, is ignored. It does not change the command, mode or divider of the cycle in progress.
- R10: An abort while cs_n is low drives cs_n high and sclk low at the next clock edge. No result_valid follows, and result keeps its previous value.
- R11: In paused mode, if EOC has not fallen within EOC_TO_CLKS clocks of waiting, cs_n goes high and timeout is set, and no result_valid follows. timeout clears when the next start is accepted.
- R12: busy is high from the clock edge that accepts a start until the guard interval ends. cs_n is never low while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion cycle |
| cmd | input | 8 | Command byte sent to the ADC |
| int_mode | input | 1 | 1: paused mode (wait for EOC), 0: continuous 32-clock mode |
| half_div | input | DIV_W | SCLK half-period in system clocks (0 is treated as 1) |
| abort | input | 1 | End the current cycle at once |
| dout | input | 1 | Serial data from the ADC |
| eoc | input | 1 | End-of-conversion from the ADC, active falling edge |
| cs_n | output | 1 | Chip select to the ADC, active low |
| sclk | output | 1 | Serial clock to the ADC |
| din | output | 1 | Serial data to the ADC |
| result | output | 16 | Last completed conversion result |
| result_valid | output | 1 | One-clock pulse when result is updated |
| timeout | output | 1 | Set when the EOC wait expires |
| busy | output | 1 | A cycle or its guard interval is in progress |

## Verification
The hardest case to reach is the paused wait, where nothing happens at the pins until EOC falls. The test must show both that SCLK stays frozen there and how long it takes SCLK to restart after the fall. The bench contains a behavioural converter that counts SCLK edges. It holds EOC high for a chosen number of clocks after the eighth edge, checks that the edge count has not moved, and then drops EOC. It measures the time to the ninth rising edge for each divider setting. Continuous cycles with a stray EOC pulse, a cycle whose EOC never falls, and aborts in the middle of shifting cover the other paths out of the wait and the shift.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DIV_W       = 4,
  parameter int CSW_CLKS    = 6,
  parameter int EOC_TO_CLKS = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cmd,
  input  logic             int_mode,
  input  logic [DIV_W-1:0] half_div,
  input  logic             abort,
  input  logic             dout,
  input  logic             eoc,
  output logic             cs_n,
  output logic             sclk,
  output logic             din,
  output logic [15:0]      result,
  output logic             result_valid,
  output logic             timeout,
  output logic             busy
);

  localparam int WW = $clog2(EOC_TO_CLKS + 1);
  localparam int GW = $clog2(CSW_CLKS + 1);
  localparam logic [WW-1:0] WAIT_LAST  = WW'(EOC_TO_CLKS - 1);
  localparam logic [GW-1:0] GUARD_LAST = GW'(CSW_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_GUARD} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_q, hcnt;
  logic [5:0]       ecnt;
  logic [7:0]       cmd_sh;
  logic [15:0]      cap;
  logic             mode_q, pend;
  logic [2:0]       eoc_q;
  logic [WW-1:0]    wcnt;
  logic [GW-1:0]    gcnt;

  wire [DIV_W-1:0] eff      = (half_div == '0) ? DIV_W'(1) : half_div;
  wire             eoc_fall = eoc_q[2] & ~eoc_q[1];
  wire [5:0]       last_e   = mode_q ? 6'd24 : 6'd32;
  wire             cap_win  = mode_q ? (ecnt >= 6'd8) : (ecnt >= 6'd16);
  wire             tick     = (hcnt == div_q - DIV_W'(1));

  assign din  = cmd_sh[7];
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      cmd_sh <= '0;
      div_q <= DIV_W'(1);
      hcnt <= '0;
      ecnt <= '0;
      cap <= '0;
      mode_q <= 1'b0;
      pend <= 1'b0;
      eoc_q <= '0;
      wcnt <= '0;
      gcnt <= '0;
      result <= '0;
      result_valid <= 1'b0;
      timeout <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      eoc_q <= {eoc_q[1:0], eoc};
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN;
          cs_n <= 1'b0;
          sclk <= 1'b0;
          cmd_sh <= cmd;
          mode_q <= int_mode;
          div_q <= eff;
          hcnt <= '0;
          ecnt <= '0;
          timeout <= 1'b0;
        end
        S_RUN: if (abort) begin
          cs_n <= 1'b1;
          sclk <= 1'b0;
          cmd_sh <= '0;
          gcnt <= '0;
          st <= S_GUARD;
        end else if (tick) begin
          hcnt <= '0;
          sclk <= ~sclk;
          if (!sclk) begin
            ecnt <= ecnt + 6'd1;
            if (cap_win) cap <= {cap[14:0], dout};
          end else begin
            cmd_sh <= {cmd_sh[6:0], 1'b0};
            if (ecnt == last_e) begin
              cs_n <= 1'b1;
              pend <= 1'b1;
              gcnt <= '0;
              st <= S_GUARD;
            end else if (mode_q && ecnt == 6'd8) begin
              wcnt <= '0;
              st <= S_WAIT;
            end
          end
        end else begin
          hcnt <= hcnt + DIV_W'(1);
        end
        S_WAIT: if (abort) begin
          cs_n <= 1'b1;
          cmd_sh <= '0;
          gcnt <= '0;
          st <= S_GUARD;
        end else if (eoc_fall) begin
          hcnt <= '0;
          st <= S_RUN;
        end else if (wcnt == WAIT_LAST) begin
          cs_n <= 1'b1;
          timeout <= 1'b1;
          gcnt <= '0;
          st <= S_GUARD;
        end else begin
          wcnt <= wcnt + WW'(1);
        end
        default: begin
          if (pend) begin
            result <= cap;
            result_valid <= 1'b1;
            pend <= 1'b0;
          end
          gcnt <= gcnt + GW'(1);
          if (gcnt == GUARD_LAST) st <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int CSW_CLKS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic din,
  input logic abort,
  input logic result_valid,
  input logic timeout,
  input logic busy
);

  logic [15:0] hicnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hicnt <= 16'(CSW_CLKS);
    else if (!cs_n) hicnt <= '0;
    else if (hicnt != 16'hffff) hicnt <= hicnt + 16'd1;
  end

  a_r2_din_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(din) |-> !sclk);

  a_r3_sclk_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r7_valid_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && $past(cs_n)));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r8_cs_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hicnt >= 16'(CSW_CLKS)));

  a_r10_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !cs_n) |=> (cs_n && !sclk && !result_valid));

  a_r11_timeout_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> cs_n);

  a_r12_busy_cover_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.CSW_CLKS(CSW_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
  .abort(abort), .result_valid(result_valid), .timeout(timeout), .busy(busy)
);

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/1ps
module adc_conv_seq_bench;
  localparam int DIV_W = 4;
  localparam int CSW   = 6;
  localparam int TO    = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, int_mode = 1'b0, abort = 1'b0, dout = 1'b0, eoc = 1'b1;
  logic [7:0] cmd = '0;
  logic [DIV_W-1:0] half_div = '0;
  logic cs_n, sclk, din, result_valid, timeout, busy;
  logic [15:0] result;

  int checks = 0, errors = 0;
  int rx_cnt = 0, vcnt = 0;
  logic [7:0] rx_cmd = '0;
  logic [15:0] m_w = '0, last_w = '0;
  bit m_int = 1'b0;
  realtime t_r1, t_r2, t_r9, t_drop;

  always #2.5 clk = ~clk;

  adc_conv_seq #(.DIV_W(DIV_W), .CSW_CLKS(CSW), .EOC_TO_CLKS(TO)) u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .int_mode(int_mode),
    .half_div(half_div), .abort(abort), .dout(dout), .eoc(eoc), .cs_n(cs_n),
    .sclk(sclk), .din(din), .result(result), .result_valid(result_valid),
    .timeout(timeout), .busy(busy));

  always @(posedge sclk) if (!cs_n) begin
    rx_cnt = rx_cnt + 1;
    if (rx_cnt <= 8) rx_cmd = {rx_cmd[6:0], din};
    if (rx_cnt == 1) t_r1 = $realtime;
    if (rx_cnt == 2) t_r2 = $realtime;
    if (rx_cnt == 9) t_r9 = $realtime;
  end

  always @(negedge sclk) if (!cs_n) begin
    if (m_int) begin
      if (rx_cnt >= 9 && rx_cnt <= 23) dout = m_w[23-rx_cnt];
    end else if (rx_cnt >= 16 && rx_cnt <= 31) dout = m_w[31-rx_cnt];
  end

  always @(posedge clk) if (result_valid) vcnt = vcnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_cycle(input [7:0] c, input [15:0] w, input bit im, input int hd);
    rx_cnt = 0; rx_cmd = '0; m_int = im; m_w = w; vcnt = 0;
    @(negedge clk);
    cmd = c; int_mode = im; half_div = DIV_W'(hd); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 5000 && rx_cnt < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic run_cycle(input [7:0] c, input [15:0] w, input bit im, input int hd,
                           input int edly, input bit poke);
    int eff;
    eff = (hd == 0) ? 1 : hd;
    begin_cycle(c, w, im, hd);
    chk(busy && !cs_n, "R12 busy/cs after start", {30'd0, busy, cs_n}, 2);
    if (poke) begin
      wait_rx(4);
      cmd = ~c; int_mode = ~im; half_div = DIV_W'(eff + 2); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (im) begin
      wait_rx(8);
      repeat (edly) @(negedge clk);
      chk(rx_cnt == 8 && !sclk, "R5 sclk frozen before EOC", rx_cnt, 8);
      eoc = 1'b0; dout = w[15]; t_drop = $realtime;
    end else if (edly > 0) begin
      repeat (edly) @(negedge clk);
      eoc = 1'b0;
      repeat (2) @(negedge clk);
      eoc = 1'b1;
    end
    for (int i = 0; i < 5000 && !result_valid; i++) @(negedge clk);
    chk(result_valid && cs_n, "R7 valid with cs high", {30'd0, result_valid, cs_n}, 3);
    chk(result == w, im ? "R5 result" : "R4 result", result, w);
    chk(rx_cmd == c, "R2 command bits", rx_cmd, c);
    chk(rx_cnt == (im ? 24 : 32), im ? "R5 edge count" : "R4 edge count", rx_cnt, im ? 24 : 32);
    chk(t_r2 - t_r1 == 10.0 * eff, "R3 sclk period", int'(t_r2 - t_r1), 10 * eff);
    if (im)
      chk(t_r9 - t_drop == 5.0 * (2 + eff) + 2.5, "R6 restart latency",
          int'((t_r9 - t_drop) * 10), int'((5.0 * (2 + eff) + 2.5) * 10));
    else if (edly > 0)
      chk(rx_cnt == 32, "R6 stray EOC ignored", rx_cnt, 32);
    @(negedge clk);
    chk(!result_valid && result == w, "R7 pulse single and held", result_valid, 0);
    eoc = 1'b1;
    wait_idle();
    chk(vcnt == 1, "R7 one pulse per cycle", vcnt, 1);
    last_w = w;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !din && !busy && !result_valid && !timeout && result == 0,
        "R1 reset state", {cs_n, sclk, din, busy}, 8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int im = 0; im < 2; im++)
      for (int hd = 0; hd < 4; hd++)
        for (int k = 0; k < 3; k++) begin
          logic [15:0] w;
          logic [7:0] c;
          w = 16'hA5C3 ^ (16'(k) * 16'h3B1D) ^ (16'(hd) << 9) ^ (16'(im) << 3);
          if (k == 2) w = (im == 1) ? 16'hFFFF : 16'h0001;
          c = 8'h9C ^ 8'(k * 53 + hd * 17 + im * 5);
          run_cycle(c, w, im[0], hd, im ? 4 + 7 * k + hd : (k == 1 ? 12 + hd : 0), k == 0);
        end

    // R8 and R9: hold start during guard, cs_n must not fall early
    begin_cycle(8'h3A, 16'h1234, 1'b0, 1);
    for (int i = 0; i < 5000 && !result_valid; i++) @(negedge clk);
    begin
      int hc;
      hc = 1;
      start = 1'b1; cmd = 8'hC5;
      for (int i = 0; i < 100 && cs_n; i++) begin
        @(negedge clk);
        if (cs_n) hc++;
      end
      start = 1'b0;
      chk(hc == CSW, "R8 cs high guard length", hc, CSW);
    end
    last_w = 16'h1234;

    // R10: abort the restarted cycle early, then mid-readout
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs_n && !sclk, "R10 abort early", {cs_n, sclk}, 2);
    wait_idle();

    begin_cycle(8'h66, 16'hBEEF, 1'b0, 2);
    wait_rx(20);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs_n && !sclk, "R10 abort cs/sclk", {cs_n, sclk}, 2);
    repeat (60) @(negedge clk);
    chk(vcnt == 0, "R10 no valid after abort", vcnt, 0);
    chk(result == last_w, "R10 result kept", result, last_w);
    chk(!busy, "R12 idle after guard", busy, 0);

    // R11: EOC never falls
    begin_cycle(8'h0F, 16'h5555, 1'b1, 1);
    for (int i = 0; i < 2000 && !timeout; i++) @(negedge clk);
    chk(timeout && cs_n, "R11 timeout raises cs", {timeout, cs_n}, 3);
    chk(rx_cnt == 8, "R11 no sclk after timeout", rx_cnt, 8);
    wait_idle();
    chk(vcnt == 0 && result == last_w, "R11 no valid on timeout", vcnt, 0);
    begin_cycle(8'hE1, 16'h0F0F, 1'b0, 1);
    chk(!timeout, "R11 timeout cleared by start", timeout, 0);
    for (int i = 0; i < 5000 && !result_valid; i++) @(negedge clk);
    chk(result == 16'h0F0F, "R4 result after timeout", result, 16'h0F0F);
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule